// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block sits beside a small microcontroller core and decides which clock domains run while the core sleeps. The core gives it three things: a sleep-permit bit, a two-bit mode code, and a one-cycle strobe that marks the execution of its sleep instruction. When the strobe arrives while the permit bit is set, the block stores the mode code and removes the clock enables and the oscillator enable that the chosen mode does not need. It keeps the CPU, flash, I/O and ADC domains and the main oscillator as separate enables.

While asleep, the block watches seven wake-up request lines and masks them according to the stored mode. In the deepest mode, the external level request counts only after it has stayed high for a minimum number of cycles. When an accepted request arrives, the core is held for the oscillator start-up time plus four more cycles. The block then restores every clock and gives a one-cycle pulse that sends the core into its interrupt path. A reset request that arrives during sleep follows the same sequence, but its final pulse sends the core to the reset path instead.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep strobe while the permit bit is 0 has no effect: `sleeping` stays 0 and all five enables stay 1. With the permit bit at 1, `sleeping` is 1 in the cycle after the strobe.
- R2: The mode code is read at the strobe and held until wake-up: 00 = Idle, 01 = ADC quiet, 10 = Power-down, 11 = Idle.
- R3: While sleeping in Idle, the CPU and flash enables are 0 and the I/O, ADC and oscillator enables are 1.
- R4: While sleeping in ADC quiet mode, only the ADC and oscillator enables are 1.
- R5: While sleeping in Power-down, all five enables are 0.
- R6: Wake-up request bit order is [0] external level, [1] external edge, [2] pin change, [3] memory ready, [4] ADC done, [5] other I/O, [6] watchdog. In Idle, each one of them wakes the block.
- R7: In ADC quiet mode, bits 1 and 5 are ignored, and bits 0, 2, 3, 4 and 6 wake the block.
- R8: In Power-down, bits 1, 3, 4 and 5 are ignored, and only the qualified level (bit 0), pin change and watchdog wake the block.
- R9: In Power-down, the level request wakes the block only after it has been sampled high on LVL_HOLD consecutive edges. A shorter pulse does not wake it, and any low sample restarts the count.
- R10: After an accepted request, `cpu_hold` stays 1 and the CPU enable stays 0 for D = start-up + 4 cycles, with start-up 0 in Idle and STARTUP_CYC otherwise. Then `wake_irq` pulses for one cycle with all enables at 1.
- R11: A reset request during sleep wakes the block in every mode, with the same delay. It then pulses `wake_reset` instead of `wake_irq`, and it wins over a wake-up request that arrives at the same time.
- R12: After block reset, the block is running: all enables 1, `sleeping`, `cpu_hold`, `wake_irq` and `wake_reset` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset of this block |
| sleep_permit | input | 1 | Sleep is allowed when 1 |
| sleep_mode | input | 2 | Requested sleep mode code |
| sleep_strobe | input | 1 | One-cycle pulse for the sleep instruction |
| wake_ext_level | input | 1 | External level-triggered request |
| wake_ext_edge | input | 1 | External edge-triggered request |
| wake_pin_chg | input | 1 | Pin change request |
| wake_mem_rdy | input | 1 | Memory-ready request |
| wake_adc_done | input | 1 | ADC conversion complete request |
| wake_other_io | input | 1 | Other I/O interrupt request |
| wake_wdog | input | 1 | Watchdog request |
| wake_rst_req | input | 1 | Reset request from the chip |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| sleeping | output | 1 | 1 while waiting for a wake-up |
| cpu_hold | output | 1 | 1 from sleep entry until resume |
| wake_irq | output | 1 | One-cycle resume-into-interrupt pulse |
| wake_reset | output | 1 | One-cycle resume-into-reset pulse |

## Verification
Inputs change one time unit after a rising edge, and outputs are read at that same point. `sleeping` and the new enables therefore show up one edge after the strobe. A raw request ends `sleeping` one edge after it is raised. A Power-down level request ends it only after LVL_HOLD + 1 edges. The resume pulse comes at exactly D + 1 edges after the request is raised, so the bench counts edges up to the pulse and compares the count with D + 1 worked out from the mode. For ignored requests, the bench holds the request for several edges and reads `sleeping` and `cpu_hold` before it presents the next stimulus.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int unsigned SRC_N      = 7;
  localparam int unsigned SRC_LEVEL  = 0;
  localparam int unsigned SRC_EDGE   = 1;
  localparam int unsigned SRC_PIN    = 2;
  localparam int unsigned SRC_MEM    = 3;
  localparam int unsigned SRC_ADC    = 4;
  localparam int unsigned SRC_OTHER  = 5;
  localparam int unsigned SRC_WDOG   = 6;
  localparam int unsigned HOLD_EXTRA = 4;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_QUIET = 2'b01,
    MODE_PDOWN = 2'b10
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2,
    ST_RESUME = 2'd3
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic osc;
  } clk_cfg_t;

  // Code 11 has no mode of its own and falls back to Idle.
  function automatic slp_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   return MODE_QUIET;
      2'b10:   return MODE_PDOWN;
      default: return MODE_IDLE;
    endcase
  endfunction

  function automatic clk_cfg_t mode_clocks(input slp_mode_e m);
    clk_cfg_t c;
    c = '0;
    case (m)
      MODE_IDLE: begin
        c.io  = 1'b1;
        c.adc = 1'b1;
        c.osc = 1'b1;
      end
      MODE_QUIET: begin
        c.adc = 1'b1;
        c.osc = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [SRC_N-1:0] mode_wake_mask(input slp_mode_e m);
    logic [SRC_N-1:0] k;
    k = '0;
    case (m)
      MODE_IDLE:  k = '1;
      MODE_QUIET: begin
        k[SRC_LEVEL] = 1'b1;
        k[SRC_PIN]   = 1'b1;
        k[SRC_MEM]   = 1'b1;
        k[SRC_ADC]   = 1'b1;
        k[SRC_WDOG]  = 1'b1;
      end
      default: begin
        k[SRC_LEVEL] = 1'b1;
        k[SRC_PIN]   = 1'b1;
        k[SRC_WDOG]  = 1'b1;
      end
    endcase
    return k;
  endfunction

  // Total cycles the core stays held after an accepted wake request.
  function automatic int unsigned wake_delay(input slp_mode_e m,
                                             input int unsigned startup);
    return ((m == MODE_IDLE) ? 0 : startup) + HOLD_EXTRA;
  endfunction

endpackage

// File: rtl/slp_level_filter.sv
module slp_level_filter #(
  parameter int unsigned LVL_HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic level_ok_o
);
  localparam int unsigned HW = $clog2(LVL_HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(LVL_HOLD);

  logic [HW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!level_i) begin
      run_cnt <= '0;
    end else if (run_cnt != HOLD_V) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign level_ok_o = (run_cnt == HOLD_V);

  initial begin
    assert_filter_hold_positive_R9: assert (LVL_HOLD >= 1)
      else $error("LVL_HOLD must be at least 1");
  end

  // R9: a qualified level is only reported after the input was high.
  assert_level_ok_after_high_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    level_ok_o |-> $past(level_i));

endmodule

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  slp_state_e        state_i,
  input  slp_mode_e         mode_i,
  output clk_cfg_t          clk_cfg_o,
  output logic [SRC_N-1:0]  wake_mask_o
);
  clk_cfg_t sleep_cfg;

  always_comb begin
    sleep_cfg   = mode_clocks(mode_i);
    wake_mask_o = mode_wake_mask(mode_i);
    case (state_i)
      ST_SLEEP: clk_cfg_o = sleep_cfg;
      ST_WAKE: begin
        clk_cfg_o     = sleep_cfg;
        clk_cfg_o.osc = 1'b1;
      end
      default: clk_cfg_o = '1;
    endcase
  end

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
  import slp_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_permit,
  input  logic [1:0] sleep_mode,
  input  logic       sleep_strobe,
  input  logic       wake_any,
  input  logic       rst_req,
  output slp_state_e state_o,
  output slp_mode_e  mode_o,
  output logic       entry_evt,
  output logic       wake_evt,
  output logic       wake_irq,
  output logic       wake_reset
);
  localparam int unsigned MAX_D = STARTUP_CYC + HOLD_EXTRA;
  localparam int unsigned CW    = $clog2(MAX_D + 1);

  slp_state_e    state;
  slp_mode_e     mode_q;
  logic [CW-1:0] cnt;
  logic          path_rst;

  assign entry_evt = (state == ST_RUN) && sleep_strobe && sleep_permit;
  assign wake_evt  = (state == ST_SLEEP) && (wake_any || rst_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      mode_q   <= MODE_IDLE;
      cnt      <= '0;
      path_rst <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (entry_evt) begin
            state  <= ST_SLEEP;
            mode_q <= decode_mode(sleep_mode);
          end
        end
        ST_SLEEP: begin
          if (wake_evt) begin
            state    <= ST_WAKE;
            cnt      <= CW'(wake_delay(mode_q, STARTUP_CYC) - 1);
            path_rst <= rst_req;
          end
        end
        ST_WAKE: begin
          if (rst_req) path_rst <= 1'b1;
          if (cnt == '0) state <= ST_RESUME;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          state    <= ST_RUN;
          path_rst <= 1'b0;
        end
      endcase
    end
  end

  assign state_o    = state;
  assign mode_o     = mode_q;
  assign wake_irq   = (state == ST_RESUME) && !path_rst;
  assign wake_reset = (state == ST_RESUME) && path_rst;

  // R1: a strobe without permission keeps the core running.
  assert_no_entry_without_permit_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sleep_strobe && !sleep_permit) |=> (state == ST_RUN));

  // R2: the stored mode cannot change outside the running state.
  assert_mode_held_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |=> $stable(mode_q));

  // R10: the resume pulse lasts a single cycle.
  assert_irq_single_cycle_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  // R11: interrupt and reset resume are never signalled together.
  assert_irq_reset_exclusive_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(wake_irq && wake_reset));

  // R11: a reset request in sleep always leaves sleep.
  assert_reset_wakes_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && rst_req) |=> (state == ST_WAKE));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 16,
  parameter int unsigned LVL_HOLD    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_permit,
  input  logic [1:0] sleep_mode,
  input  logic       sleep_strobe,
  input  logic       wake_ext_level,
  input  logic       wake_ext_edge,
  input  logic       wake_pin_chg,
  input  logic       wake_mem_rdy,
  input  logic       wake_adc_done,
  input  logic       wake_other_io,
  input  logic       wake_wdog,
  input  logic       wake_rst_req,
  output logic       clk_en_cpu,
  output logic       clk_en_flash,
  output logic       clk_en_io,
  output logic       clk_en_adc,
  output logic       osc_en,
  output logic       sleeping,
  output logic       cpu_hold,
  output logic       wake_irq,
  output logic       wake_reset
);
  slp_state_e       state;
  slp_mode_e        mode_q;
  clk_cfg_t         clk_cfg;
  logic [SRC_N-1:0] wake_mask;
  logic [SRC_N-1:0] wake_src;
  logic [SRC_N-1:0] wake_hit;
  logic             level_ok;
  logic             level_eff;
  logic             wake_any;
  logic             entry_evt;
  logic             wake_evt;

  slp_level_filter #(.LVL_HOLD(LVL_HOLD)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (wake_ext_level),
    .level_ok_o(level_ok)
  );

  // The deepest mode takes only the qualified level.
  assign level_eff = (mode_q == MODE_PDOWN) ? level_ok : wake_ext_level;

  assign wake_src = {wake_wdog, wake_other_io, wake_adc_done, wake_mem_rdy,
                     wake_pin_chg, wake_ext_edge, level_eff};

  slp_mode_decode u_decode (
    .state_i    (state),
    .mode_i     (mode_q),
    .clk_cfg_o  (clk_cfg),
    .wake_mask_o(wake_mask)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_hit
    assign wake_hit[g] = wake_src[g] & wake_mask[g];
  end
  assign wake_any = |wake_hit;

  slp_wake_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_permit(sleep_permit),
    .sleep_mode  (sleep_mode),
    .sleep_strobe(sleep_strobe),
    .wake_any    (wake_any),
    .rst_req     (wake_rst_req),
    .state_o     (state),
    .mode_o      (mode_q),
    .entry_evt   (entry_evt),
    .wake_evt    (wake_evt),
    .wake_irq    (wake_irq),
    .wake_reset  (wake_reset)
  );

  assign clk_en_cpu   = clk_cfg.cpu;
  assign clk_en_flash = clk_cfg.flash;
  assign clk_en_io    = clk_cfg.io;
  assign clk_en_adc   = clk_cfg.adc;
  assign osc_en       = clk_cfg.osc;
  assign sleeping     = (state == ST_SLEEP);
  assign cpu_hold     = (state == ST_SLEEP) || (state == ST_WAKE);

  // R1: an accepted strobe is followed by sleep.
  assert_entry_sleeps_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    entry_evt |=> sleeping);

  // R3: Idle keeps peripheral clocks and stops the core.
  assert_idle_clocks_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sleeping && mode_q == MODE_IDLE) |->
      (!clk_en_cpu && !clk_en_flash && clk_en_io && clk_en_adc && osc_en));

  // R4: ADC quiet mode keeps only the converter and oscillator.
  assert_quiet_clocks_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sleeping && mode_q == MODE_QUIET) |->
      (!clk_en_cpu && !clk_en_flash && !clk_en_io && clk_en_adc && osc_en));

  // R5: Power-down stops everything.
  assert_pdown_dark_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sleeping && mode_q == MODE_PDOWN) |->
      $countones({clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_en}) == 0);

  // R8: unqualified sources keep Power-down asleep.
  assert_pdown_ignores_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sleeping && mode_q == MODE_PDOWN && !level_ok && !wake_pin_chg &&
     !wake_wdog && !wake_rst_req) |=> sleeping);

  // R10: the core clock stays off for as long as the core is held.
  assert_hold_gates_cpu_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    cpu_hold |-> !clk_en_cpu);

  // R10: resume comes with every clock enabled.
  assert_resume_all_on_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wake_irq || wake_reset) |->
      (clk_en_cpu && clk_en_flash && clk_en_io && clk_en_adc && osc_en && !cpu_hold));

  // R10: leaving sleep always passes through the held state.
  assert_wake_holds_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    wake_evt |=> (cpu_hold && !sleeping));

endmodule

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;
  localparam int unsigned STARTUP = 16;
  localparam int unsigned HOLD    = 8;
  localparam int unsigned D_IDLE  = 4;
  localparam int unsigned D_DEEP  = STARTUP + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic permit = 1'b0;
  logic [1:0] mode = 2'b00;
  logic strobe = 1'b0;
  logic [6:0] src = '0;
  logic rst_req = 1'b0;
  logic en_cpu, en_flash, en_io, en_adc, en_osc;
  logic sleeping, cpu_hold, wake_irq, wake_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_ctrl #(.STARTUP_CYC(STARTUP), .LVL_HOLD(HOLD)) i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sleep_permit(permit), .sleep_mode(mode), .sleep_strobe(strobe),
    .wake_ext_level(src[0]), .wake_ext_edge(src[1]), .wake_pin_chg(src[2]),
    .wake_mem_rdy(src[3]), .wake_adc_done(src[4]), .wake_other_io(src[5]),
    .wake_wdog(src[6]), .wake_rst_req(rst_req),
    .clk_en_cpu(en_cpu), .clk_en_flash(en_flash), .clk_en_io(en_io),
    .clk_en_adc(en_adc), .osc_en(en_osc),
    .sleeping(sleeping), .cpu_hold(cpu_hold),
    .wake_irq(wake_irq), .wake_reset(wake_reset)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clocks();
    return {en_cpu, en_flash, en_io, en_adc, en_osc};
  endfunction

  task automatic enter_sleep(input logic [1:0] code);
    permit = 1'b1;
    mode   = code;
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
    permit = 1'b0;
    chk(sleeping == 1'b1, "R1 sleep after permitted strobe", sleeping, 1);
  endtask

  // Counts edges from the current point to the resume pulse.
  task automatic time_wake(input int exp_n, input bit want_rst, input string tag);
    int n = 0;
    bit held = 1'b1;
    bit pulse = 1'b0;
    while (!pulse && n < 200) begin
      tick();
      n++;
      pulse = wake_irq || wake_reset;
      if (!pulse && (!cpu_hold || en_cpu)) held = 1'b0;
    end
    chk(n == exp_n, {tag, " resume delay"}, n, exp_n);
    chk(held, {tag, " core held until resume"}, held, 1);
    chk(wake_reset == want_rst && wake_irq == !want_rst, {tag, " resume path"},
        {wake_irq, wake_reset}, {!want_rst, want_rst});
    chk(clocks() == 5'h1f, "R10 all clocks on at resume", clocks(), 5'h1f);
    src = '0;
    rst_req = 1'b0;
    tick();
    chk(!wake_irq && !wake_reset && !cpu_hold, "R10 pulse lasts one cycle",
        {wake_irq, wake_reset}, 0);
  endtask

  task automatic t_reset();
    chk(clocks() == 5'h1f, "R12 reset clocks", clocks(), 5'h1f);
    chk(!sleeping && !cpu_hold && !wake_irq && !wake_reset, "R12 reset flags",
        {sleeping, cpu_hold, wake_irq, wake_reset}, 0);
  endtask

  task automatic t_no_permit();
    permit = 1'b0;
    mode   = 2'b10;
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
    tick();
    chk(!sleeping && !cpu_hold, "R1 strobe without permit ignored", sleeping, 0);
    chk(clocks() == 5'h1f, "R1 clocks unchanged", clocks(), 5'h1f);
  endtask

  task automatic t_idle_all_sources();
    for (int i = 0; i < 7; i++) begin
      enter_sleep(2'b00);
      chk(clocks() == 5'b00111, "R3 idle clocks", clocks(), 5'b00111);
      src[i] = 1'b1;
      time_wake(D_IDLE + 1, 1'b0, "R6 idle source");
    end
  endtask

  task automatic t_code11();
    enter_sleep(2'b11);
    chk(clocks() == 5'b00111, "R2 code 11 acts as idle", clocks(), 5'b00111);
    src[6] = 1'b1;
    time_wake(D_IDLE + 1, 1'b0, "R2 code 11 delay");
  endtask

  task automatic t_quiet();
    enter_sleep(2'b01);
    chk(clocks() == 5'b00011, "R4 quiet clocks", clocks(), 5'b00011);
    src[1] = 1'b1;
    repeat (10) tick();
    chk(sleeping && cpu_hold, "R7 edge request ignored", sleeping, 1);
    src = '0;
    src[5] = 1'b1;
    repeat (10) tick();
    chk(sleeping && cpu_hold, "R7 other io ignored", sleeping, 1);
    src = '0;
    src[4] = 1'b1;
    time_wake(D_DEEP + 1, 1'b0, "R7 adc wakes quiet");
    enter_sleep(2'b01);
    src[0] = 1'b1;
    time_wake(D_DEEP + 1, 1'b0, "R7 level wakes quiet");
    tick();
  endtask

  task automatic t_pdown();
    enter_sleep(2'b10);
    chk(clocks() == 0, "R5 power-down clocks", clocks(), 0);
    for (int b = 1; b < 6; b++) begin
      if (b != 2) begin
        src = '0;
        src[b] = 1'b1;
        repeat (6) tick();
        chk(sleeping, "R8 source ignored in power-down", b, -1);
      end
    end
    src = '0;
    src[0] = 1'b1;
    repeat (HOLD - 1) tick();
    src[0] = 1'b0;
    repeat (4) tick();
    chk(sleeping, "R9 short level pulse ignored", sleeping, 1);
    src[0] = 1'b1;
    repeat (HOLD) tick();
    chk(sleeping, "R9 level not yet qualified", sleeping, 1);
    tick();
    chk(!sleeping && cpu_hold, "R9 qualified level wakes", sleeping, 0);
    time_wake(D_DEEP, 1'b0, "R10 power-down level");
    enter_sleep(2'b10);
    src[6] = 1'b1;
    time_wake(D_DEEP + 1, 1'b0, "R8 watchdog wakes power-down");
    enter_sleep(2'b10);
    src[2] = 1'b1;
    time_wake(D_DEEP + 1, 1'b0, "R8 pin change wakes power-down");
  endtask

  task automatic t_reset_wake();
    enter_sleep(2'b10);
    rst_req = 1'b1;
    time_wake(D_DEEP + 1, 1'b1, "R11 reset in power-down");
    enter_sleep(2'b00);
    rst_req = 1'b1;
    src[6] = 1'b1;
    time_wake(D_IDLE + 1, 1'b1, "R11 reset wins over watchdog");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_no_permit();
    t_idle_all_sources();
    t_code11();
    t_quiet();
    t_pdown();
    t_reset_wake();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    #2;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule